// File: doc/BRIEF.md
# Power-On Strap Capture Latch

This block lets four package pins serve two purposes. While power-on reset is held, the pins act as configuration straps. Each pin has a board resistor pulling it high or low. The block brings each pin level into the reference-clock domain through a two-stage synchronizer and loads it into a 4-bit configuration register on every reset-window edge. The value loaded on the last such edge is the one that is kept.

The first reference-clock edge that sees reset released does three things at once:

- It freezes the register.
- It raises a capture-done flag.
- It turns on the output enable of every shared pin.

From then on each pin carries its assigned clock. The stored value is decoded into a 3-bit frequency select, a bus-clock mode bit and a production-test flag, and downstream clock generation reads these fields. Until capture is done, the decoded fields show the value that four undriven pins would give: every pin reads 1 through its pull-up.

The reset input `por_n` is sampled on the reference clock, which must run during the reset window. The register keeps its value until the next assertion of `por_n`, and that assertion starts a new capture.

Top module: `strap_capture_latch`

## Requirements
- R1: Pin index 0 holds the bus-mode strap, index 1 holds frequency select bit 0, index 2 bit 1 and index 3 bit 2. After capture, `cfg_fsel` = {pin3, pin2, pin1} as captured.
- R2: The captured value is the pad level that was present two reference-clock edges before the last edge with `por_n` low. A pad change made after that edge is not captured.
- R3: While `por_n` is sampled low, `pad_oe` is all zeros and `pad_out` is all zeros.
- R4: `cfg_done` and every `pad_oe` bit rise on the first reference-clock edge at which `por_n` is sampled high.
- R5: While `cfg_done` is low, the decoded outputs read as the all-ones pull-up default: `cfg_fsel` = 3'b111, `cfg_bus_sync` = 1 and `cfg_test` = 0.
- R6: Once `cfg_done` is high, `pad_out[i]` follows `clk_src[i]` for every pin.
- R7: After capture, `cfg_test` is 1 exactly when the captured select is frequency bit 2 = 0, bit 1 = 1 and bit 0 = 1 (`cfg_fsel` = 3'b011).
- R8: After capture, `cfg_bus_sync` equals the captured pin 0 level. A value of 1 selects a bus clock locked at half the CPU rate; a value of 0 selects a fixed, unrelated bus rate.
- R9: After capture, pad input changes do not affect the decoded outputs, which stay the same until `por_n` is asserted again.
- R10: Asserting `por_n` again clears `cfg_done` and `pad_oe` on the next edge, and a later release captures the new strap levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, running during reset |
| por_n | input | 1 | Power-on reset, active low, sampled on `clk` |
| pad_in | input | 4 | Levels read back from the shared pins |
| clk_src | input | 4 | Clocks to drive onto the pins once operating |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output value |
| cfg_done | output | 1 | Capture completed; decoded fields valid |
| cfg_fsel | output | 3 | Captured frequency select |
| cfg_bus_sync | output | 1 | 1 = bus clock at half CPU rate, 0 = fixed bus rate |
| cfg_test | output | 1 | Production-test select decoded |

## Verification
The assertions check four rules on every cycle:

- Pins stay undriven through the reset window.
- Enables track the done flag.
- Defaults hold before capture.
- Decoded fields stay frozen while `por_n` stays high.

They also check that a raised test flag implies the 3'b011 select and that a disabled pin outputs zero. Only the bench scenarios can show which pad sample ends up stored. These scenarios cover:

- the two-edge synchronizer latency at the release boundary;
- the bit-to-field mapping for all sixteen strap values;
- the test and bus-mode decodes for each value;
- recapture after a second reset.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int unsigned PIN_COUNT  = 4;
    localparam int unsigned FSEL_WIDTH = 3;

    // Pin positions are fixed by board wiring
    localparam int unsigned PIN_BUS  = 0;
    localparam int unsigned PIN_FS0  = 1;

    // Select code for production test: fs2=0 fs1=1 fs0=1
    localparam logic [FSEL_WIDTH-1:0] FSEL_TEST = 3'b011;

    typedef struct packed {
        logic [FSEL_WIDTH-1:0] fsel;
        logic                  bus_sync;
        logic                  test;
    } strap_cfg_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stage;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.stage[0] = async_in;
        for (int s = 1; s < int'(STAGES); s++) begin
            state_d.stage[s] = state_q.stage[s-1];
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign sync_out = state_q.stage[STAGES-1];

endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_pkg::*;
#(
    parameter int unsigned WIDTH = PIN_COUNT
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] strap_sync,
    output logic             done,
    output strap_cfg_t       cfg
);

    localparam logic [WIDTH-1:0] PULLUP_DEFAULT = '1;

    typedef struct packed {
        logic [WIDTH-1:0] strap;
        logic             done;
    } latch_state_t;

    latch_state_t state_d, state_q;
    logic [WIDTH-1:0] view;

    always_comb begin
        state_d = state_q;
        if (!por_n) begin
            state_d.strap = strap_sync;
            state_d.done  = 1'b0;
        end else begin
            state_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign done = state_q.done;
    assign view = state_q.done ? state_q.strap : PULLUP_DEFAULT;

    always_comb begin
        cfg.fsel     = view[PIN_FS0 +: FSEL_WIDTH];
        cfg.bus_sync = view[PIN_BUS];
        cfg.test     = state_q.done && (view[PIN_FS0 +: FSEL_WIDTH] == FSEL_TEST);
    end

endmodule

// File: rtl/strap_pad_mux.sv
module strap_pad_mux #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             enable,
    input  logic [WIDTH-1:0] clk_src,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    for (genvar i = 0; i < int'(WIDTH); i++) begin : g_pin
        assign pad_oe[i]  = enable;
        assign pad_out[i] = enable & clk_src[i];
    end

endmodule

// File: rtl/strap_capture_latch.sv
module strap_capture_latch
    import strap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [PIN_COUNT-1:0]  pad_in,
    input  logic [PIN_COUNT-1:0]  clk_src,
    output logic [PIN_COUNT-1:0]  pad_oe,
    output logic [PIN_COUNT-1:0]  pad_out,
    output logic                  cfg_done,
    output logic [FSEL_WIDTH-1:0] cfg_fsel,
    output logic                  cfg_bus_sync,
    output logic                  cfg_test
);

    logic [PIN_COUNT-1:0] pad_synced;
    strap_cfg_t           cfg;
    logic                 done;

    strap_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (pad_in),
        .sync_out (pad_synced)
    );

    strap_latch #(.WIDTH(PIN_COUNT)) u_latch (
        .clk        (clk),
        .por_n      (por_n),
        .strap_sync (pad_synced),
        .done       (done),
        .cfg        (cfg)
    );

    strap_pad_mux #(.WIDTH(PIN_COUNT)) u_mux (
        .enable  (done),
        .clk_src (clk_src),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    assign cfg_done     = done;
    assign cfg_fsel     = cfg.fsel;
    assign cfg_bus_sync = cfg.bus_sync;
    assign cfg_test     = cfg.test;

endmodule

// File: rtl/strap_capture_latch_chk.sv
module strap_capture_latch_chk (
    input logic       clk,
    input logic       por_n,
    input logic [3:0] pad_oe,
    input logic [3:0] pad_out,
    input logic       cfg_done,
    input logic [2:0] cfg_fsel,
    input logic       cfg_bus_sync,
    input logic       cfg_test
);

    logic started_q = 1'b0;
    always_ff @(posedge clk) started_q <= 1'b1;

    AST_OE_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!started_q)
        !$past(por_n) |-> (pad_oe == 4'b0000 && !cfg_done)); // R3

    AST_OE_WITH_DONE: assert property (@(posedge clk) disable iff (!started_q)
        cfg_done |-> (pad_oe == 4'b1111)); // R4

    AST_PULLUP_DEFAULT: assert property (@(posedge clk) disable iff (!started_q)
        !cfg_done |-> (cfg_fsel == 3'b111 && cfg_bus_sync && !cfg_test)); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_done && $past(cfg_done)) |-> ($stable(cfg_fsel) && $stable(cfg_bus_sync) && $stable(cfg_test))); // R9

    AST_TEST_CODE: assert property (@(posedge clk) disable iff (!started_q)
        cfg_test |-> (cfg_fsel == 3'b011 && cfg_done)); // R7

    AST_PAD_QUIET: assert property (@(posedge clk) disable iff (!started_q)
        (pad_oe == 4'b0000) |-> (pad_out == 4'b0000)); // R3

endmodule

bind strap_capture_latch strap_capture_latch_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .cfg_done     (cfg_done),
    .cfg_fsel     (cfg_fsel),
    .cfg_bus_sync (cfg_bus_sync),
    .cfg_test     (cfg_test)
);

// File: tb/strap_capture_latch_bench.sv
module strap_capture_latch_bench;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [3:0] pad_in = 4'b1111;
    logic [3:0] clk_src = 4'b0000;
    logic [3:0] pad_oe, pad_out;
    logic       cfg_done;
    logic [2:0] cfg_fsel;
    logic       cfg_bus_sync, cfg_test;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    strap_capture_latch u_strap_capture_latch (
        .clk          (clk),
        .por_n        (por_n),
        .pad_in       (pad_in),
        .clk_src      (clk_src),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out),
        .cfg_done     (cfg_done),
        .cfg_fsel     (cfg_fsel),
        .cfg_bus_sync (cfg_bus_sync),
        .cfg_test     (cfg_test)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, actual, expected, $time);
        end
    endtask

    task automatic check_defaults(input string req);
        check(cfg_fsel == 3'b111, req, int'(cfg_fsel), 7);
        check(cfg_bus_sync == 1'b1, req, int'(cfg_bus_sync), 1);
        check(cfg_test == 1'b0, req, int'(cfg_test), 0);
    endtask

    // Enter reset with pads set to val, hold for hold_edges, release, wait one edge
    task automatic capture(input logic [3:0] val, input int hold_edges);
        @(negedge clk);
        por_n  = 1'b0;
        pad_in = val;
        repeat (hold_edges) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // Reset state from time zero
        pad_in  = 4'b0101;
        clk_src = 4'b1111;
        repeat (3) @(negedge clk);
        check(pad_oe == 4'b0000, "R3", int'(pad_oe), 0);
        check(pad_out == 4'b0000, "R3", int'(pad_out), 0);
        check(cfg_done == 1'b0, "R3", int'(cfg_done), 0);
        check_defaults("R5");

        // Sweep every strap value
        for (int v = 0; v < 16; v++) begin
            logic [3:0] val;
            logic [2:0] exp_fsel;
            val = 4'(v);
            exp_fsel = val[3:1];

            // Re-entering reset clears done and enables on the next edge
            @(negedge clk);
            por_n = 1'b0;
            pad_in = val;
            @(negedge clk);
            check(cfg_done == 1'b0, "R10", int'(cfg_done), 0);
            check(pad_oe == 4'b0000, "R10", int'(pad_oe), 0);
            repeat (4) @(negedge clk);
            check(pad_oe == 4'b0000, "R3", int'(pad_oe), 0);
            check_defaults("R5");
            por_n = 1'b1;
            @(negedge clk);
            check(cfg_done == 1'b1, "R4", int'(cfg_done), 1);
            check(pad_oe == 4'b1111, "R4", int'(pad_oe), 15);
            check(cfg_fsel == exp_fsel, "R1", int'(cfg_fsel), int'(exp_fsel));
            check(cfg_bus_sync == val[0], "R8", int'(cfg_bus_sync), int'(val[0]));
            check(cfg_test == (exp_fsel == 3'b011), "R7", int'(cfg_test), int'(exp_fsel == 3'b011));

            // Each pin follows its own clock source
            for (int p = 0; p < 4; p++) begin
                clk_src = 4'(1 << p) ^ val;
                #1;
                check(pad_out == clk_src, "R6", int'(pad_out), int'(clk_src));
            end

            // Pad changes after release do not reach the decoded outputs
            pad_in = ~val;
            repeat (4) @(negedge clk);
            check(cfg_fsel == exp_fsel, "R9", int'(cfg_fsel), int'(exp_fsel));
            check(cfg_bus_sync == val[0], "R9", int'(cfg_bus_sync), int'(val[0]));
        end

        // Synchronizer latency at the release boundary
        capture(4'b1010, 5);
        @(negedge clk);
        por_n = 1'b0;
        pad_in = 4'b0011;
        repeat (5) @(negedge clk);
        pad_in = 4'b1100;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check(cfg_fsel == 3'b001, "R2", int'(cfg_fsel), 1);
        check(cfg_bus_sync == 1'b1, "R2", int'(cfg_bus_sync), 1);

        @(negedge clk);
        por_n = 1'b0;
        pad_in = 4'b0011;
        repeat (5) @(negedge clk);
        pad_in = 4'b1100;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check(cfg_fsel == 3'b110, "R2", int'(cfg_fsel), 6);
        check(cfg_bus_sync == 1'b0, "R2", int'(cfg_bus_sync), 0);

        // Undriven pins read high through the pull-ups: all-ones strap
        capture(4'b1111, 4);
        check(cfg_fsel == 3'b111 && cfg_bus_sync && !cfg_test, "R1", int'({cfg_fsel, cfg_bus_sync}), 15);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule